// File: doc/BRIEF.md
# Bus Cycle Halt Controller

This block runs bus cycles on an asynchronous external bus whose ports can be 8 or 16 bits wide. A requester hands over one operand of one, two or four bytes. The block splits the operand into port-sized pieces. Each piece is one bus cycle that walks through states S0 to S5. The piece completes when the slave returns a data-size acknowledge, or it ends early on a bus error. Read pieces are packed into a right-justified result with the most significant byte first. Write pieces are placed on the data lanes that the slave reads.

A halt input lets external logic freeze the bus. The halt input is asynchronous and is synchronized before use. When it is seen, the bus stops at the next piece boundary, after the acknowledge has negated. While the bus is stopped, the strobes are inactive and the data bus is released. Address, function code, size and direction keep the values of the last cycle. Releasing halt lets the paused operand continue from the next byte that has not yet moved. Releasing halt briefly and then applying it again lets exactly one more piece run, so the bus can be stepped one cycle at a time. A bus error is always reported, even while halt is applied.

Top module: `bus_halt_ctrl`

## Requirements
- R1: After reset, `bus_as_n` and `bus_ds_n` are 1, `bus_data_oe` is 0, `rsp_done` and `rsp_berr` are 0, and `req_ready` is 1 while halt is not applied.
- R2: `req_size` is coded 0 = byte, 1 = word, 2 = long. A piece is two bytes when the port is 16 bits wide (`port16` = 1), at least two bytes remain and the piece address is even; otherwise it is one byte. The address advances by the piece size. During each piece, `bus_siz` equals the number of bytes still to move, modulo 4. The address does not change while `bus_as_n` is 0.
- R3: Read results are right-justified in `rsp_rdata`, with the first piece most significant. A two-byte piece reads `bus_data_in[15:0]`. A one-byte piece reads `bus_data_in[7:0]` when the port is 16 bits wide and the address is odd, and reads `bus_data_in[15:8]` otherwise.
- R4: Write operands are taken right-justified from `req_wdata`, most significant byte first. A two-byte piece drives its bytes on `bus_data_out[15:0]`. A one-byte piece drives its byte on both lanes. `bus_data_oe` is 1 during write pieces.
- R5: `bus_ds_n` is 0 only while `bus_as_n` is 0, and `bus_data_oe` is 1 only while `bus_ds_n` is 0.
- R6: When `halt_n` is 0 and the synchronized halt is seen before a piece boundary, no further piece starts. When halt is released, the transfer resumes at the next byte. No completed piece is repeated.
- R7: While the bus is stopped, `bus_as_n` and `bus_ds_n` are 1 and `bus_data_oe` is 0. `bus_addr`, `bus_fc`, `bus_siz` and `bus_rw` keep the values of the last piece.
- R8: Releasing `halt_n` for a short time and then applying it again lets exactly one more piece run before the bus stops again.
- R9: When `berr_n` is 0 in the acknowledge wait state, the transfer ends. `rsp_done` and `rsp_berr` pulse together for one cycle, and `rsp_rdata` is all ones. This also happens while halt is applied.
- R10: `rsp_done` without `rsp_berr` is raised only after every piece of the operand has completed. `rsp_done` is a single-cycle pulse.
- R11: While the synchronized halt is applied, `req_ready` is 0 and no new request starts a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Request is accepted on this edge if valid |
| req_addr | input | ADDR_W | Operand start address |
| req_fc | input | FC_W | Function code for the transfer |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_wdata | input | 32 | Write operand, right-justified |
| rsp_done | output | 1 | Transfer finished (one-cycle pulse) |
| rsp_berr | output | 1 | Transfer ended by bus error (pulse with done) |
| rsp_rdata | output | 32 | Read result, valid with done |
| port16 | input | 1 | Responding port is 16 bits wide |
| dsack_n | input | 1 | Data-size acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Asynchronous halt request, active low |
| bus_as_n | output | 1 | Address strobe |
| bus_ds_n | output | 1 | Data strobe |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_data_out | output | 16 | Write data lanes |
| bus_data_in | input | 16 | Read data lanes |
| bus_addr | output | ADDR_W | Bus address |
| bus_fc | output | FC_W | Bus function code |
| bus_siz | output | 2 | Bytes still to move, modulo 4 |
| bus_rw | output | 1 | Bus direction, 1 = read |

## Verification
The assertions check four properties on every cycle. The data strobe and the output enable stay inside the address strobe. The address stays put while a strobe is active. Address, function code, size and direction are frozen while the bus is stopped. A bus-error flag never appears without the one-cycle done pulse.

Some behaviours show only over a whole transfer, so the bench scenarios cover them. These are:
- where the bus stops inside a split operand,
- that exactly one piece runs per halt release,
- that a resumed transfer continues at the next byte,
- the lane placement and the assembled read values,
- that a request is refused while halt is applied.

// File: rtl/bch_pkg.sv
package bch_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_S0,
      ST_S1,
      ST_S2,
      ST_S3,
      ST_S4,
      ST_S5,
      ST_HALT
   } bus_st_e;

   localparam int OPND_BYTES = 4;
   localparam int REM_W      = 3;
   localparam int DBUS_W     = 16;

   // operand size code to byte count: 0 byte, 1 word, 2/3 long
   function automatic logic [REM_W-1:0] size_to_bytes(input logic [1:0] code);
      logic [REM_W-1:0] n;
      case (code)
         2'd0:    n = 3'd1;
         2'd1:    n = 3'd2;
         default: n = 3'd4;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/bch_sync.sv
module bch_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("bch_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bch_piece_calc.sv
module bch_piece_calc
   import bch_pkg::*;
#(
   parameter bit WIDE_PORT_EN = 1'b1
) (
   input  logic [REM_W-1:0]  rem,
   input  logic              addr0,
   input  logic              port16,
   input  logic [31:0]       wdata,
   output logic              k_two,
   output logic [REM_W-1:0]  rem_left,
   output logic [DBUS_W-1:0] wr_lanes
);
   generate
      if (WIDE_PORT_EN) begin : g_wide
         assign k_two = port16 && (rem >= 3'd2) && !addr0;
      end else begin : g_narrow
         logic unused_port;
         assign unused_port = port16;
         assign k_two = 1'b0;
      end
   endgenerate

   logic [REM_W-1:0] kv;
   logic [4:0]       sh;
   logic [31:0]      shifted;

   always_comb begin
      kv       = k_two ? 3'd2 : 3'd1;
      rem_left = rem - kv;
      sh       = {rem_left[1:0], 3'b000};
      shifted  = wdata >> sh;
      if (k_two) wr_lanes = shifted[15:0];
      else       wr_lanes = {shifted[7:0], shifted[7:0]};
   end
endmodule

// File: rtl/bch_rd_assemble.sv
module bch_rd_assemble
   import bch_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fill,
   input  logic              latch,
   input  logic              k_two,
   input  logic              port16,
   input  logic              addr0,
   input  logic [DBUS_W-1:0] din,
   output logic [31:0]       rdata
);
   logic [7:0] byte_lane;

   always_comb begin
      if (port16 && addr0) byte_lane = din[7:0];
      else                 byte_lane = din[15:8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (clr)    rdata <= '0;
      else if (fill)   rdata <= '1;
      else if (latch) begin
         if (k_two) rdata <= {rdata[15:0], din};
         else       rdata <= {rdata[23:0], byte_lane};
      end
   end
endmodule

// File: rtl/bch_seq.sv
module bch_seq
   import bch_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int FC_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [FC_W-1:0]   req_fc,
   input  logic              req_rw,
   input  logic [1:0]        req_size,
   input  logic              port16_in,
   input  logic              dsack_n,
   input  logic              berr_n,
   input  logic              halt_s,
   input  logic              k_two,
   input  logic [REM_W-1:0]  rem_left,
   output bus_st_e           st,
   output logic [ADDR_W-1:0] addr_q,
   output logic [FC_W-1:0]   fc_q,
   output logic              rw_q,
   output logic [1:0]        siz_q,
   output logic [REM_W-1:0]  rem_q,
   output logic              port16_q,
   output logic              req_ready,
   output logic              accept,
   output logic              done_q,
   output logic              berr_q
);
   logic [ADDR_W-1:0] nxt_addr;
   logic [ADDR_W-1:0] step_addr;
   logic [REM_W-1:0]  first_rem;

   assign req_ready = (st == ST_IDLE) && !halt_s;
   assign accept    = req_ready && req_valid;
   assign step_addr = addr_q + (k_two ? ADDR_W'(2) : ADDR_W'(1));
   assign first_rem = size_to_bytes(req_size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         addr_q   <= '0;
         nxt_addr <= '0;
         fc_q     <= '0;
         rw_q     <= 1'b1;
         siz_q    <= '0;
         rem_q    <= '0;
         port16_q <= 1'b0;
         done_q   <= 1'b0;
         berr_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         berr_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= req_addr;
                  fc_q   <= req_fc;
                  rw_q   <= req_rw;
                  rem_q  <= first_rem;
                  siz_q  <= first_rem[1:0];
                  st     <= ST_S0;
               end
            end
            ST_S0: begin
               port16_q <= port16_in;
               st       <= ST_S1;
            end
            ST_S1: st <= ST_S2;
            ST_S2: st <= ST_S3;
            ST_S3: begin
               if (!berr_n) begin
                  done_q <= 1'b1;
                  berr_q <= 1'b1;
                  rem_q  <= '0;
                  st     <= ST_IDLE;
               end else if (!dsack_n) begin
                  st <= ST_S4;
               end
            end
            ST_S4: st <= ST_S5;
            ST_S5: begin
               if (dsack_n && berr_n) begin
                  if (rem_left == '0) begin
                     done_q <= 1'b1;
                     rem_q  <= '0;
                     st     <= ST_IDLE;
                  end else begin
                     rem_q    <= rem_left;
                     nxt_addr <= step_addr;
                     if (halt_s) begin
                        st <= ST_HALT;
                     end else begin
                        addr_q <= step_addr;
                        siz_q  <= rem_left[1:0];
                        st     <= ST_S0;
                     end
                  end
               end
            end
            ST_HALT: begin
               if (!halt_s) begin
                  addr_q <= nxt_addr;
                  siz_q  <= rem_q[1:0];
                  st     <= ST_S0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bus_halt_ctrl.sv
module bus_halt_ctrl
   import bch_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int FC_W         = 3,
   parameter int SYNC_STAGES  = 2,
   parameter bit WIDE_PORT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [FC_W-1:0]   req_fc,
   input  logic              req_rw,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_done,
   output logic              rsp_berr,
   output logic [31:0]       rsp_rdata,
   input  logic              port16,
   input  logic              dsack_n,
   input  logic              berr_n,
   input  logic              halt_n,
   output logic              bus_as_n,
   output logic              bus_ds_n,
   output logic              bus_data_oe,
   output logic [15:0]       bus_data_out,
   input  logic [15:0]       bus_data_in,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [FC_W-1:0]   bus_fc,
   output logic [1:0]        bus_siz,
   output logic              bus_rw
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("bus_halt_ctrl: ADDR_W must be at least 4");
      end
      if (FC_W < 1) begin : g_bad_fc
         $error("bus_halt_ctrl: FC_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bus_halt_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   bus_st_e          st;
   logic             halt_s;
   logic             k_two;
   logic [REM_W-1:0] rem_q;
   logic [REM_W-1:0] rem_left;
   logic             port16_q;
   logic             accept;
   logic [31:0]      wdata_q;
   logic             halted_w;
   logic             as_act;
   logic             ds_act;

   bch_sync #(.STAGES(SYNC_STAGES)) u_halt_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (~halt_n),
      .q     (halt_s)
   );

   bch_seq #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_fc    (req_fc),
      .req_rw    (req_rw),
      .req_size  (req_size),
      .port16_in (port16),
      .dsack_n   (dsack_n),
      .berr_n    (berr_n),
      .halt_s    (halt_s),
      .k_two     (k_two),
      .rem_left  (rem_left),
      .st        (st),
      .addr_q    (bus_addr),
      .fc_q      (bus_fc),
      .rw_q      (bus_rw),
      .siz_q     (bus_siz),
      .rem_q     (rem_q),
      .port16_q  (port16_q),
      .req_ready (req_ready),
      .accept    (accept),
      .done_q    (rsp_done),
      .berr_q    (rsp_berr)
   );

   bch_piece_calc #(.WIDE_PORT_EN(WIDE_PORT_EN)) u_calc (
      .rem      (rem_q),
      .addr0    (bus_addr[0]),
      .port16   (port16_q),
      .wdata    (wdata_q),
      .k_two    (k_two),
      .rem_left (rem_left),
      .wr_lanes (bus_data_out)
   );

   bch_rd_assemble u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .fill   ((st == ST_S3) && !berr_n),
      .latch  (st == ST_S4),
      .k_two  (k_two),
      .port16 (port16_q),
      .addr0  (bus_addr[0]),
      .din    (bus_data_in),
      .rdata  (rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wdata_q <= '0;
      else if (accept) wdata_q <= req_wdata;
   end

   always_comb begin
      as_act = (st == ST_S1) || (st == ST_S2) || (st == ST_S3) || (st == ST_S4);
      ds_act = (st == ST_S2) || (st == ST_S3) || (st == ST_S4);
   end

   assign bus_as_n    = !as_act;
   assign bus_ds_n    = !ds_act;
   assign bus_data_oe = ds_act && !bus_rw;
   assign halted_w    = (st == ST_HALT);
endmodule

// File: rtl/bch_checker.sv
module bch_checker #(
   parameter int ADDR_W = 24,
   parameter int FC_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_as_n,
   input logic              bus_ds_n,
   input logic              bus_data_oe,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [FC_W-1:0]   bus_fc,
   input logic [1:0]        bus_siz,
   input logic              bus_rw,
   input logic              rsp_done,
   input logic              rsp_berr,
   input logic              halted
);
   a_r5_ds_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ds_n |-> !bus_as_n);

   a_r5_oe_inside_ds: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe |-> !bus_ds_n);

   a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_addr));

   a_r7_frozen_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && $past(halted)) |->
         ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_siz) && $stable(bus_rw)));

   a_r9_berr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_berr |-> rsp_done);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
endmodule

bind bus_halt_ctrl bch_checker #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_as_n    (bus_as_n),
   .bus_ds_n    (bus_ds_n),
   .bus_data_oe (bus_data_oe),
   .bus_addr    (bus_addr),
   .bus_fc      (bus_fc),
   .bus_siz     (bus_siz),
   .bus_rw      (bus_rw),
   .rsp_done    (rsp_done),
   .rsp_berr    (rsp_berr),
   .halted      (halted_w)
);

// File: tb/bus_halt_ctrl_tb.sv
module bus_halt_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int FW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [FW-1:0] req_fc = '0;
   logic          req_rw = 1'b1;
   logic [1:0]    req_size = '0;
   logic [31:0]   req_wdata = '0;
   logic          rsp_done, rsp_berr;
   logic [31:0]   rsp_rdata;
   logic          port16 = 1'b0;
   logic          dsack_n = 1'b1;
   logic          berr_n = 1'b1;
   logic          halt_n = 1'b1;
   logic          bus_as_n, bus_ds_n, bus_data_oe, bus_rw;
   logic [15:0]   bus_data_out, bus_data_in;
   logic [AW-1:0] bus_addr;
   logic [FW-1:0] bus_fc;
   logic [1:0]    bus_siz;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit err_mode = 1'b0;
   bit prev_ds = 1'b1;
   int n_cyc = 0;
   int strobe_bad = 0;
   logic [AW-1:0] log_addr [0:7];
   logic [15:0]   log_dat  [0:7];
   logic [1:0]    log_siz  [0:7];
   logic          log_oe   [0:7];
   logic [31:0]   got_rdata;
   logic          got_berr;
   bit            got_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_halt_ctrl #(.ADDR_W(AW), .FC_W(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_fc(req_fc), .req_rw(req_rw), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_berr(rsp_berr),
      .rsp_rdata(rsp_rdata), .port16(port16), .dsack_n(dsack_n), .berr_n(berr_n),
      .halt_n(halt_n), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
      .bus_data_oe(bus_data_oe), .bus_data_out(bus_data_out),
      .bus_data_in(bus_data_in), .bus_addr(bus_addr), .bus_fc(bus_fc),
      .bus_siz(bus_siz), .bus_rw(bus_rw)
   );

   function automatic logic [7:0] mb(input logic [3:0] a);
      return 8'h40 + {4'h0, a};
   endfunction

   assign bus_data_in = port16 ? {mb({bus_addr[3:1], 1'b0}), mb({bus_addr[3:1], 1'b1})}
                               : {mb(bus_addr[3:0]), 8'h00};

   // slave model: acknowledge (or error) one half-cycle after the data strobe
   always @(negedge clk) begin
      if (!rst_n) begin
         dsack_n <= 1'b1;
         berr_n  <= 1'b1;
         prev_ds <= 1'b1;
      end else begin
         if (!bus_ds_n && bus_as_n) strobe_bad++;
         if (!bus_ds_n && prev_ds && n_cyc < 8) begin
            log_addr[n_cyc] <= bus_addr;
            log_dat[n_cyc]  <= bus_data_out;
            log_siz[n_cyc]  <= bus_siz;
            log_oe[n_cyc]   <= bus_data_oe;
            n_cyc++;
         end
         prev_ds <= bus_ds_n;
         if (!bus_ds_n) begin
            if (err_mode) berr_n <= 1'b0;
            else          dsack_n <= 1'b0;
         end else begin
            dsack_n <= 1'b1;
            berr_n  <= 1'b1;
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog expired: act=%0d cycles exp<=100000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", what, act, exp);
      end
   endtask

   task automatic start(input logic rw, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] wd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      n_cyc     = 0;
      req_rw    = rw;
      req_size  = sz;
      req_addr  = a;
      req_wdata = wd;
      req_fc    = 3'd5;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      got_done = 1'b0;
      while (t < 300 && !got_done) begin
         if (rsp_done) begin
            got_done  = 1'b1;
            got_rdata = rsp_rdata;
            got_berr  = rsp_berr;
         end else begin
            @(negedge clk);
            t++;
         end
      end
   endtask

   task automatic wait_first_ds();
      int t = 0;
      while (bus_ds_n && t < 100) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic t_reset();
      chk("R1 as_n at reset", {31'd0, bus_as_n}, 32'd1);
      chk("R1 ds_n at reset", {31'd0, bus_ds_n}, 32'd1);
      chk("R1 oe at reset", {31'd0, bus_data_oe}, 32'd0);
      chk("R1 done/berr at reset", {30'd0, rsp_done, rsp_berr}, 32'd0);
      chk("R1 ready at reset", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic t_reads();
      port16 = 1'b0;
      start(1'b1, 2'd0, 24'd5, '0); wait_done();
      chk("R3 byte/8 rdata", got_rdata, {24'd0, mb(4'd5)});
      chk("R2 byte/8 cycles", n_cyc, 1);
      chk("R2 byte/8 siz", {30'd0, log_siz[0]}, 32'd1);
      start(1'b1, 2'd1, 24'd4, '0); wait_done();
      chk("R3 word/8 rdata", got_rdata, {16'd0, mb(4'd4), mb(4'd5)});
      chk("R10 word/8 cycles at done", n_cyc, 2);
      chk("R2 word/8 siz seq", {28'd0, log_siz[0], log_siz[1]}, {28'd0, 2'd2, 2'd1});
      chk("R2 word/8 addr 2nd", {8'd0, log_addr[1]}, 32'd5);
      port16 = 1'b1;
      start(1'b1, 2'd2, 24'd4, '0); wait_done();
      chk("R3 long/16 rdata", got_rdata, {mb(4'd4), mb(4'd5), mb(4'd6), mb(4'd7)});
      chk("R2 long/16 cycles", n_cyc, 2);
      chk("R2 long/16 addrs", {8'd0, log_addr[0][7:0], log_addr[1][7:0]}, 32'h0406);
      chk("R2 long/16 siz seq", {28'd0, log_siz[0], log_siz[1]}, {28'd0, 2'd0, 2'd2});
      start(1'b1, 2'd0, 24'd7, '0); wait_done();
      chk("R3 byte/16 odd lane", got_rdata, {24'd0, mb(4'd7)});
      port16 = 1'b0;
   endtask

   task automatic t_writes();
      port16 = 1'b1;
      start(1'b0, 2'd2, 24'd0, 32'hCAFE_1234); wait_done();
      chk("R4 long/16 lanes 1st", {16'd0, log_dat[0]}, 32'h0000_CAFE);
      chk("R4 long/16 lanes 2nd", {16'd0, log_dat[1]}, 32'h0000_1234);
      chk("R4 oe during write", {31'd0, log_oe[0]}, 32'd1);
      port16 = 1'b0;
      start(1'b0, 2'd0, 24'd3, 32'h0000_005A); wait_done();
      chk("R4 byte/8 both lanes", {16'd0, log_dat[0]}, 32'h0000_5A5A);
   endtask

   task automatic t_halt_word();
      port16 = 1'b0;
      start(1'b1, 2'd1, 24'd2, '0);
      wait_first_ds();
      halt_n = 1'b0;
      repeat (15) @(negedge clk);
      chk("R6 pieces before stop", n_cyc, 1);
      chk("R7 strobes while stopped", {29'd0, bus_as_n, bus_ds_n, bus_data_oe}, 32'b110);
      chk("R7 addr held", {8'd0, bus_addr}, 32'd2);
      chk("R7 siz/rw/fc held", {26'd0, bus_siz, bus_rw, bus_fc}, {26'd0, 2'd2, 1'b1, 3'd5});
      repeat (10) @(negedge clk);
      chk("R6 still stopped, no done", {30'd0, 1'(n_cyc), rsp_done}, 32'b10);
      halt_n = 1'b1;
      wait_done();
      chk("R6 resumed total pieces", n_cyc, 2);
      chk("R6 resume next byte addr", {8'd0, log_addr[1]}, 32'd3);
      chk("R6 resumed rdata", got_rdata, {16'd0, mb(4'd2), mb(4'd3)});
   endtask

   task automatic t_single_step();
      port16 = 1'b0;
      start(1'b1, 2'd2, 24'd8, '0);
      wait_first_ds();
      halt_n = 1'b0;
      repeat (14) @(negedge clk);
      chk("R8 stopped after piece 1", n_cyc, 1);
      halt_n = 1'b1; repeat (2) @(negedge clk); halt_n = 1'b0;
      repeat (16) @(negedge clk);
      chk("R8 one step -> 2 pieces", n_cyc, 2);
      chk("R8 step addr held", {8'd0, bus_addr}, 32'd9);
      chk("R8 step siz held", {30'd0, bus_siz}, 32'd3);
      halt_n = 1'b1; repeat (2) @(negedge clk); halt_n = 1'b0;
      repeat (16) @(negedge clk);
      chk("R8 second step -> 3 pieces", n_cyc, 3);
      halt_n = 1'b1;
      wait_done();
      chk("R10 long/8 pieces at done", n_cyc, 4);
      chk("R6 no repeated address",
          {log_addr[0][7:0], log_addr[1][7:0], log_addr[2][7:0], log_addr[3][7:0]},
          32'h08090A0B);
      chk("R3 stepped long rdata", got_rdata, {mb(4'd8), mb(4'd9), mb(4'd10), mb(4'd11)});
      chk("R2 long/8 siz seq",
          {24'd0, log_siz[0], log_siz[1], log_siz[2], log_siz[3]}, {24'd0, 8'b00_11_10_01});
   endtask

   task automatic t_block_start();
      halt_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11 ready low under halt", {31'd0, req_ready}, 32'd0);
      n_cyc     = 0;
      req_rw    = 1'b1; req_size = 2'd0; req_addr = 24'd1; req_valid = 1'b1;
      repeat (10) @(negedge clk);
      chk("R11 no cycle under halt", n_cyc, 0);
      chk("R11 as_n idle under halt", {31'd0, bus_as_n}, 32'd1);
      req_valid = 1'b0;
      halt_n = 1'b1;
      start(1'b1, 2'd0, 24'd1, '0); wait_done();
      chk("R11 runs after release", got_rdata, {24'd0, mb(4'd1)});
   endtask

   task automatic t_berr();
      port16 = 1'b0;
      err_mode = 1'b1;
      start(1'b1, 2'd0, 24'd6, '0); wait_done();
      chk("R9 berr flagged", {30'd0, 1'(got_done), got_berr}, 32'b11);
      chk("R9 rdata all ones", got_rdata, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R9 single-cycle pulse", {30'd0, rsp_done, rsp_berr}, 32'd0);
      // bus error while halt applied mid-piece
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      n_cyc = 0;
      req_rw = 1'b1; req_size = 2'd2; req_addr = 24'd8; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      halt_n = 1'b0;
      wait_done();
      chk("R9 berr reported under halt", {30'd0, 1'(got_done), got_berr}, 32'b11);
      chk("R9 under halt rdata ones", got_rdata, 32'hFFFF_FFFF);
      chk("R9 ended after one piece", n_cyc, 1);
      err_mode = 1'b0;
      halt_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reads();
      t_writes();
      t_halt_word();
      t_single_step();
      t_block_start();
      t_berr();
      chk("R5 strobe order violations", strobe_bad, 0);
      summary();
      $finish;
   end
endmodule